// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Reload-Counter Baud Timing

This block receives asynchronous serial bytes on a single line. Its timing comes from a programmable rate generator: one of two clock sources (the system clock as is, or the system clock divided by eight) drives a down-counter. The counter reloads from an 8-bit value `n`, so the source is divided by `n+1`. Each reload produces an oversampling tick, and sixteen ticks make one bit time. A 9615 bit/s link at a 16 MHz clock therefore uses the undivided source with `n = 103`.

The line passes through a two-stage synchroniser before edge detection. A falling edge starts a frame. Each bit is sampled on the 8th oversampling tick counted from that edge. A start bit that is high at its sample point is treated as noise, and the receiver returns to idle. Eight data bits arrive least significant first, followed by one stop bit. The finished byte is copied into a holding register, and a full flag and an interrupt request are raised. The interrupt request is cleared by an acknowledge pulse or by a software clear strobe. A read strobe empties the holding register. A request-to-send output, active low, tells the far end whether the receiver can take a byte.

Top module: `serial_rx`

## Requirements
- R1: After reset `rx_full`, `irq_req`, `frame_err`, `overrun` and `rx_data` are 0 and `rts_n` is 1.
- R2: One bit time is 16*(n+1) source periods, where n is `reload`. The source period is one clock cycle when `src_sel`=0 and eight clock cycles when `src_sel`=1.
- R3: A low pulse on `rxd` that has ended before the 8th oversampling tick after its falling edge is discarded: no byte and no flag results.
- R4: The first bit after the start bit lands in `rx_data[0]` and the eighth in `rx_data[7]`.
- R5: At the stop-bit sample, the byte is copied into `rx_data`, and `rx_full` and `irq_req` become 1 on the next clock.
- R6: `irq_ack` or `irq_clr` drives `irq_req` to 0 on the next clock. A byte completing in the same cycle takes priority.
- R7: `rd_stb` drives `rx_full` to 0 on the next clock unless a byte completes in the same cycle.
- R8: A stop bit sampled low sets `frame_err` to 1 while the byte is still stored. A byte with a high stop bit sets `frame_err` to 0.
- R9: A byte that completes while `rx_full` is 1 (and no `rd_stb` is present) sets `overrun` to 1 and replaces `rx_data`. A byte completing into an empty register sets `overrun` to 0.
- R10: While `rx_en` is 0 the receiver is held idle. A frame in progress is dropped, and line activity produces no byte.
- R11: `rts_n` is 0 only when `flow_en`, `rts_sel` and `rx_en` are all 1 and `rx_full` is 0. It follows these one clock later and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 1 | Rate source: 0 = clock, 1 = clock/8 |
| reload | input | 8 | Rate counter reload value n |
| rx_en | input | 1 | Receive enable |
| flow_en | input | 1 | Flow control enable |
| rts_sel | input | 1 | Select request-to-send output mode |
| rxd | input | 1 | Serial receive line |
| rd_stb | input | 1 | Holding register read strobe |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_clr | input | 1 | Software interrupt clear strobe |
| rx_data | output | 8 | Received byte holding register |
| rx_full | output | 1 | Byte waiting in holding register |
| irq_req | output | 1 | Receive interrupt request |
| frame_err | output | 1 | Last byte had a low stop bit |
| overrun | output | 1 | Last byte overwrote an unread byte |
| rts_n | output | 1 | Request to send, active low |

## Verification
A divider that miscounts the reload or the prescale shifts the sample point by a fraction of a bit on every bit. By the eighth data bit this shows as a corrupted `rx_data` at the end of the frame, so the sweep uses both sources and several reload values. A shifter, bit counter or state register that goes wrong shows within one frame: the byte is wrong, it never completes, or a noise pulse is accepted. Flag and request-to-send faults show one clock after the strobe that should move them.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/serial_rx_baud.sv
module serial_rx_baud #(
    parameter int CNT_W    = 8,
    parameter int PRESCALE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_sel,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } baud_t;

    baud_t baud_d, baud_q;
    logic  src_ce;

    always_comb begin
        baud_d      = baud_q;
        baud_d.tick = 1'b0;
        // prescaler runs freely; it only matters when the divided source is chosen
        baud_d.pre  = (baud_q.pre == PRE_LAST) ? '0 : baud_q.pre + 1'b1;
        src_ce      = src_sel ? (baud_q.pre == PRE_LAST) : 1'b1;
        if (src_ce) begin
            if (baud_q.cnt == '0) begin
                baud_d.cnt  = reload;
                baud_d.tick = 1'b1;
            end else begin
                baud_d.cnt  = baud_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) baud_q <= '0;
        else        baud_q <= baud_d;
    end

    assign tick = baud_q.tick;
endmodule

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic line,
    output logic fall
);
    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign line = sh_q[STAGES-1];
    assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              line,
    input  logic              fall,
    output logic              done,
    output logic              stop_err,
    output logic              busy,
    output logic [DATA_W-1:0] data
);
    localparam int OVS_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [OVS_W-1:0] SAMPLE_AT = OVS_W'(OVS / 2 - 1);
    localparam logic [OVS_W-1:0] OVS_LAST  = OVS_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [OVS_W-1:0]  ovs;
        logic [BIT_W-1:0]  bits;
        logic [DATA_W-1:0] shreg;
        logic              done;
        logic              ferr;
    } core_t;

    core_t core_d, core_q;
    logic  sample;

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        // mid-bit point: the (OVS/2)-th tick counted from the start edge
        sample      = tick && (core_q.ovs == SAMPLE_AT);
        if (!enable) begin
            core_d.state = RX_IDLE;
            core_d.ovs   = '0;
            core_d.bits  = '0;
        end else if (core_q.state == RX_IDLE) begin
            if (fall) begin
                core_d.state = RX_START;
                core_d.ovs   = '0;
                core_d.bits  = '0;
            end
        end else begin
            if (tick) begin
                core_d.ovs = (core_q.ovs == OVS_LAST) ? '0 : core_q.ovs + 1'b1;
            end
            if (sample) begin
                unique case (core_q.state)
                    RX_START: begin
                        core_d.state = line ? RX_IDLE : RX_DATA;
                    end
                    RX_DATA: begin
                        core_d.shreg = {line, core_q.shreg[DATA_W-1:1]};
                        core_d.bits  = core_q.bits + 1'b1;
                        if (core_q.bits == BIT_LAST) core_d.state = RX_STOP;
                    end
                    RX_STOP: begin
                        core_d.done  = 1'b1;
                        core_d.ferr  = ~line;
                        core_d.state = RX_IDLE;
                    end
                    default: core_d.state = RX_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q       <= '0;
            core_q.state <= RX_IDLE;
        end else begin
            core_q       <= core_d;
        end
    end

    assign done     = core_q.done;
    assign stop_err = core_q.ferr;
    assign busy     = (core_q.state != RX_IDLE);
    assign data     = core_q.shreg;
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
    parameter int CNT_W       = 8,
    parameter int PRESCALE    = 8,
    parameter int OVS         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_sel,
    input  logic [CNT_W-1:0]  reload,
    input  logic              rx_en,
    input  logic              flow_en,
    input  logic              rts_sel,
    input  logic              rxd,
    input  logic              rd_stb,
    input  logic              irq_ack,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              irq_req,
    output logic              frame_err,
    output logic              overrun,
    output logic              rts_n
);
    typedef struct packed {
        logic [DATA_W-1:0] buf_data;
        logic              full;
        logic              irq;
        logic              ferr;
        logic              ovr;
        logic              rts_n;
    } hold_t;

    hold_t             hold_d, hold_q;
    logic              os_tick;
    logic              line_s;
    logic              line_fall;
    logic              core_done;
    logic              core_ferr;
    logic              core_busy;
    logic [DATA_W-1:0] core_data;

    serial_rx_baud #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .reload  (reload),
        .tick    (os_tick)
    );

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rxd   (rxd),
        .line  (line_s),
        .fall  (line_fall)
    );

    serial_rx_core #(.DATA_W(DATA_W), .OVS(OVS)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (rx_en),
        .tick     (os_tick),
        .line     (line_s),
        .fall     (line_fall),
        .done     (core_done),
        .stop_err (core_ferr),
        .busy     (core_busy),
        .data     (core_data)
    );

    always_comb begin
        hold_d = hold_q;
        if (rd_stb)             hold_d.full = 1'b0;
        if (irq_ack || irq_clr) hold_d.irq  = 1'b0;
        if (core_done) begin
            // a completing byte takes priority over any clearing strobe
            hold_d.buf_data = core_data;
            hold_d.full     = 1'b1;
            hold_d.irq      = 1'b1;
            hold_d.ferr     = core_ferr;
            hold_d.ovr      = hold_q.full & ~rd_stb;
        end
        hold_d.rts_n = ~(flow_en & rts_sel & rx_en & ~hold_q.full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q       <= '0;
            hold_q.rts_n <= 1'b1;
        end else begin
            hold_q       <= hold_d;
        end
    end

    assign rx_data   = hold_q.buf_data;
    assign rx_full   = hold_q.full;
    assign irq_req   = hold_q.irq;
    assign frame_err = hold_q.ferr;
    assign overrun   = hold_q.ovr;
    assign rts_n     = hold_q.rts_n;
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic flow_en,
    input logic rts_sel,
    input logic rd_stb,
    input logic irq_ack,
    input logic irq_clr,
    input logic done,
    input logic busy,
    input logic rx_full,
    input logic irq_req,
    input logic rts_n
);
    AST_DONE_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (rx_full && irq_req)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_ack || irq_clr) && !done) |=> !irq_req); // R6

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !done) |=> !rx_full); // R7

    AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !busy); // R10

    AST_RTS_DEASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_en || !rts_sel || !rx_en || rx_full) |=> rts_n); // R11

    AST_RTS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && rts_sel && rx_en && !rx_full) |=> !rts_n); // R11
endmodule

bind serial_rx serial_rx_checker u_serial_rx_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .flow_en (flow_en),
    .rts_sel (rts_sel),
    .rd_stb  (rd_stb),
    .irq_ack (irq_ack),
    .irq_clr (irq_clr),
    .done    (core_done),
    .busy    (core_busy),
    .rx_full (rx_full),
    .irq_req (irq_req),
    .rts_n   (rts_n)
);

// File: tb/test_serial_rx.sv
module test_serial_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_sel = 1'b0;
    logic [7:0] reload = 8'd0;
    logic       rx_en = 1'b0;
    logic       flow_en = 1'b1;
    logic       rts_sel = 1'b1;
    logic       rxd = 1'b1;
    logic       rd_stb = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, irq_req, frame_err, overrun, rts_n;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serial_rx i_serial_rx (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .reload(reload),
        .rx_en(rx_en), .flow_en(flow_en), .rts_sel(rts_sel), .rxd(rxd),
        .rd_stb(rd_stb), .irq_ack(irq_ack), .irq_clr(irq_clr),
        .rx_data(rx_data), .rx_full(rx_full), .irq_req(irq_req),
        .frame_err(frame_err), .overrun(overrun), .rts_n(rts_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // expected bit time in clock cycles, from R2
    function automatic int bit_clks(input logic src, input int n);
        return 16 * (n + 1) * (src ? 8 : 1);
    endfunction

    task automatic send_frame(input logic [7:0] b, input logic stop_bit, input int bclk);
        rxd = 1'b0;
        wait_clk(bclk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_clk(bclk);
        end
        rxd = stop_bit;
        wait_clk(bclk);
        rxd = 1'b1;
        wait_clk(bclk);
    endtask

    task automatic strobe_read();
        rd_stb = 1'b1; wait_clk(1); rd_stb = 1'b0; wait_clk(2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] pats [4];
        int bc;
        int idx;
        pats[0] = 8'hA5; pats[1] = 8'h01; pats[2] = 8'h80; pats[3] = 8'h3C;

        wait_clk(4);
        @(negedge clk);
        check("R1 rx_full", rx_full, 0);
        check("R1 irq_req", irq_req, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 overrun", overrun, 0);
        check("R1 rx_data", rx_data, 0);
        check("R1 rts_n", rts_n, 1);
        rst_n = 1'b1;
        wait_clk(2);
        rx_en = 1'b1;
        wait_clk(3);
        check("R11 request when empty", rts_n, 0);

        // sweep of source and reload settings: R2, R4, R5, R6, R7, R11
        idx = 0;
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 3; k++) begin
                int nval;
                nval = (k == 2) ? 3 : k;
                src_sel = s[0];
                reload = nval[7:0];
                bc = bit_clks(s[0], nval);
                wait_clk(bc);
                for (int p = 0; p < 4; p++) begin
                    logic [7:0] b;
                    b = pats[p] ^ idx[7:0];
                    send_frame(b, 1'b1, bc);
                    @(negedge clk);
                    check("R2 R4 byte", rx_data, b);
                    check("R5 full", rx_full, 1);
                    check("R5 irq", irq_req, 1);
                    check("R8 stop ok", frame_err, 0);
                    check("R11 held when full", rts_n, 1);
                    if (idx[0]) begin irq_clr = 1'b1; wait_clk(1); irq_clr = 1'b0; end
                    else        begin irq_ack = 1'b1; wait_clk(1); irq_ack = 1'b0; end
                    @(negedge clk);
                    check("R6 irq cleared", irq_req, 0);
                    check("R6 full kept", rx_full, 1);
                    strobe_read();
                    @(negedge clk);
                    check("R7 read empties", rx_full, 0);
                    check("R11 request after read", rts_n, 0);
                    idx++;
                end
            end
        end

        src_sel = 1'b0;
        reload = 8'd1;
        bc = bit_clks(1'b0, 1);
        wait_clk(bc);

        // R3: short low pulse is noise
        rxd = 1'b0; wait_clk(bc / 4); rxd = 1'b1;
        wait_clk(3 * bc);
        check("R3 noise rejected full", rx_full, 0);
        check("R3 noise rejected irq", irq_req, 0);
        send_frame(8'h5A, 1'b1, bc);
        check("R3 next frame ok", rx_data, 8'h5A);
        strobe_read();

        // R8: framing error, data kept
        send_frame(8'hC3, 1'b0, bc);
        @(negedge clk);
        check("R8 frame_err", frame_err, 1);
        check("R8 data stored", rx_data, 8'hC3);
        check("R8 full", rx_full, 1);
        strobe_read();
        send_frame(8'h11, 1'b1, bc);
        @(negedge clk);
        check("R8 frame_err clears", frame_err, 0);

        // R9: overrun (register still full from 0x11)
        send_frame(8'h96, 1'b1, bc);
        @(negedge clk);
        check("R9 overrun", overrun, 1);
        check("R9 replaced", rx_data, 8'h96);
        strobe_read();
        send_frame(8'h42, 1'b1, bc);
        @(negedge clk);
        check("R9 overrun clears", overrun, 0);
        strobe_read();

        // R10: abort mid-frame, then disabled line activity
        rxd = 1'b0; wait_clk(bc);
        rxd = 1'b1; wait_clk(bc);
        rx_en = 1'b0;
        wait_clk(2);
        check("R11 disabled", rts_n, 1);
        wait_clk(9 * bc);
        rx_en = 1'b1;
        wait_clk(2 * bc);
        @(negedge clk);
        check("R10 aborted frame", rx_full, 0);
        rx_en = 1'b0;
        send_frame(8'h77, 1'b1, bc);
        @(negedge clk);
        check("R10 disabled frame", rx_full, 0);
        check("R10 data untouched", rx_data, 8'h42);
        rx_en = 1'b1;
        wait_clk(3);

        // R11: mode selection
        rts_sel = 1'b0; wait_clk(2);
        check("R11 not selected", rts_n, 1);
        rts_sel = 1'b1; flow_en = 1'b0; wait_clk(2);
        check("R11 flow off", rts_n, 1);
        flow_en = 1'b1; wait_clk(2);
        check("R11 restored", rts_n, 0);

        finish_run();
    end
endmodule